// File: doc/BRIEF.md
# Set/Clear Aliased Control Register Bank

This block holds a small bank of 32-bit control registers for a peripheral. Software never writes a register directly. Each register has three word addresses. A write to the first address turns on every bit that carries a one in the write data. A write to the second address turns off every bit that carries a one. A read of the third address returns the stored value. Bits written as zero are left alone. A single bit can therefore be changed with one store, with no read-modify-write sequence and no race with other code that owns other bits.

The bank sits in an aligned address window. The base of the window is its lowest address, and the upper address bits must match that base. A simple synchronous bus drives the block: address, write enable, write data, read enable and registered read data. Every register value is also driven out in parallel to the logic beside the block.

Top module: `sca_reg_bank`

## Requirements
- R1: Register k is decoded from the byte offset inside the window. Offset 16k+0 is its set alias, 16k+4 is its clear alias, 16k+8 is its status alias, and 16k+12 is unmapped. Address bits [1:0] are ignored. At most one register is written per cycle.
- R2: A write to a set alias forces to one every bit of that register whose write-data bit is one.
- R3: A write to a clear alias forces to zero every bit of that register whose write-data bit is one.
- R4: Bits whose write-data bit is zero keep their value after a set or clear write. Registers other than the addressed one are never changed.
- R5: A read of a status alias returns that register's value on `rd_data_o` in the cycle after `rd_en_i` is high. `rd_data_o` is zero in any cycle that follows a cycle with `rd_en_i` low.
- R6: A read of a set alias or a clear alias returns zero.
- R7: A write to a status alias changes no register.
- R8: A synchronous active-high reset clears every register and `rd_data_o` to zero.
- R9: A write takes effect at the clock edge that samples it. A read issued in the next cycle returns the new value.
- R10: Unmapped offsets inside the window, and any address whose upper bits do not match the window base, read zero and are ignored on write. The unmapped offsets are the fourth slot of each register and every slot at or above NUM_REGS.
- R11: `ctrl_o[k]` shows register k continuously, and shows the updated value right after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W (32) | Byte address of the access |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W (32) | Write data, used as a bit mask |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | DATA_W (32) | Registered read data, valid the cycle after rd_en_i |
| ctrl_o | output | NUM_REGS x DATA_W | Parallel register contents |

## Verification
The assertions check on every cycle that at most one set or clear strobe is active. Each register slice is checked so that a set write turns on the masked bits, a clear write turns them off, unmasked bits hold, and an idle register stays stable. A status-alias write is checked to leave the outputs unchanged. Read data is checked to be zero after idle cycles and after reads of non-status aliases, and to equal the selected register otherwise. Only the bench's scenarios show that the offset layout, the window base match, the unmapped slots and the slots beyond the last register map to the right targets. The same holds for the end-to-end results of a sequence of set and clear writes as software sees them.

// File: rtl/sca_pkg.sv
package sca_pkg;
    // Alias selected by byte-offset bits [3:2] within a register slot
    typedef enum logic [1:0] {
        ALIAS_SET  = 2'd0,
        ALIAS_CLR  = 2'd1,
        ALIAS_STAT = 2'd2,
        ALIAS_NONE = 2'd3
    } alias_e;

    localparam int SLOT_BYTES_LOG2 = 4;
endpackage

// File: rtl/sca_addr_decode.sv
module sca_addr_decode
    import sca_pkg::*;
#(
    parameter int          NUM_REGS  = 4,
    parameter int          ADDR_W    = 32,
    parameter int          WIN_LOG2  = 8,
    parameter logic [31:0] BASE_ADDR = 32'h4000_0000
) (
    input  logic [ADDR_W-1:0]   addr_i,
    output logic [NUM_REGS-1:0] set_sel_o,
    output logic [NUM_REGS-1:0] clr_sel_o,
    output logic [NUM_REGS-1:0] stat_sel_o
);
    localparam int SLOT_W = WIN_LOG2 - SLOT_BYTES_LOG2;

    logic              in_win;
    logic [SLOT_W-1:0] slot;
    alias_e            kind;
    logic              unused_lo;

    assign in_win    = (addr_i[ADDR_W-1:WIN_LOG2] == BASE_ADDR[ADDR_W-1:WIN_LOG2]);
    assign slot      = addr_i[WIN_LOG2-1:SLOT_BYTES_LOG2];
    assign kind      = alias_e'(addr_i[3:2]);
    assign unused_lo = ^addr_i[1:0];

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_sel
        logic hit;
        assign hit           = in_win && (slot == SLOT_W'(k));
        assign set_sel_o[k]  = hit && (kind == ALIAS_SET);
        assign clr_sel_o[k]  = hit && (kind == ALIAS_CLR);
        assign stat_sel_o[k] = hit && (kind == ALIAS_STAT);
    end
endmodule

// File: rtl/sca_reg_slice.sv
module sca_reg_slice #(
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              set_we_i,
    input  logic              clr_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] value_o
);
    typedef struct packed {
        logic [DATA_W-1:0] value;
    } slice_t;

    slice_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_we_i) begin
            st_d.value = st_q.value | wdata_i;
        end else if (clr_we_i) begin
            st_d.value = st_q.value & ~wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value_o = st_q.value;

    AST_SET_FORCES_ONES: assert property (@(posedge clk_i) disable iff (rst_i)
        set_we_i |=> ((value_o & $past(wdata_i)) == $past(wdata_i))); // R2
    AST_CLR_FORCES_ZEROS: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_we_i |=> ((value_o & $past(wdata_i)) == '0)); // R3
    AST_MASKED_BITS_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (set_we_i || clr_we_i) |=> ((value_o & ~$past(wdata_i)) == ($past(value_o) & ~$past(wdata_i)))); // R4
    AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (rst_i)
        (!set_we_i && !clr_we_i) |=> $stable(value_o)); // R4
    AST_RESET_CLEARS: assert property (@(posedge clk_i)
        rst_i |=> (value_o == '0)); // R8
endmodule

// File: rtl/sca_read_mux.sv
module sca_read_mux #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 32
) (
    input  logic                             clk_i,
    input  logic                             rst_i,
    input  logic                             rd_en_i,
    input  logic [NUM_REGS-1:0]              stat_sel_i,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  values_i,
    output logic [DATA_W-1:0]                rd_data_o
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d = '0;
        if (rd_en_i) begin
            for (int k = 0; k < NUM_REGS; k++) begin
                if (stat_sel_i[k]) begin
                    rd_d.rdata = values_i[k];
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data_o = rd_q.rdata;

    AST_IDLE_READS_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        !rd_en_i |=> (rd_data_o == '0)); // R5
    AST_NON_STATUS_READS_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_en_i && (stat_sel_i == '0)) |=> (rd_data_o == '0)); // R6

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_chk
        AST_STATUS_READ_VALUE: assert property (@(posedge clk_i) disable iff (rst_i)
            (rd_en_i && stat_sel_i[k]) |=> (rd_data_o == $past(values_i[k]))); // R5
    end
endmodule

// File: rtl/sca_reg_bank.sv
module sca_reg_bank #(
    parameter int          NUM_REGS  = 4,
    parameter int          DATA_W    = 32,
    parameter int          ADDR_W    = 32,
    parameter int          WIN_LOG2  = 8,
    parameter logic [31:0] BASE_ADDR = 32'h4000_0000
) (
    input  logic                            clk_i,
    input  logic                            rst_i,
    input  logic [ADDR_W-1:0]               addr_i,
    input  logic                            wr_en_i,
    input  logic [DATA_W-1:0]               wdata_i,
    input  logic                            rd_en_i,
    output logic [DATA_W-1:0]               rd_data_o,
    output logic [NUM_REGS-1:0][DATA_W-1:0] ctrl_o
);
    logic [NUM_REGS-1:0] set_sel, clr_sel, stat_sel;
    logic [NUM_REGS-1:0] set_we, clr_we;

    sca_addr_decode #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W),
        .WIN_LOG2 (WIN_LOG2),
        .BASE_ADDR(BASE_ADDR)
    ) u_decode (
        .addr_i    (addr_i),
        .set_sel_o (set_sel),
        .clr_sel_o (clr_sel),
        .stat_sel_o(stat_sel)
    );

    assign set_we = wr_en_i ? set_sel : '0;
    assign clr_we = wr_en_i ? clr_sel : '0;

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        sca_reg_slice #(.DATA_W(DATA_W)) u_slice (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .set_we_i(set_we[k]),
            .clr_we_i(clr_we[k]),
            .wdata_i (wdata_i),
            .value_o (ctrl_o[k])
        );
    end

    sca_read_mux #(
        .NUM_REGS(NUM_REGS),
        .DATA_W  (DATA_W)
    ) u_rdmux (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .rd_en_i   (rd_en_i),
        .stat_sel_i(stat_sel),
        .values_i  (ctrl_o),
        .rd_data_o (rd_data_o)
    );

    AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({set_we, clr_we})); // R1
    AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && (stat_sel != '0)) |=> (ctrl_o == $past(ctrl_o))); // R7
    AST_NO_TARGET_NO_CHANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && ({set_sel, clr_sel} == '0)) |=> (ctrl_o == $past(ctrl_o))); // R10
    AST_RESET_READ_ZERO: assert property (@(posedge clk_i)
        rst_i |=> (rd_data_o == '0)); // R8
endmodule

// File: tb/sca_reg_bank_tb.sv
module sca_reg_bank_tb_top;
    localparam int          NREG = 4;
    localparam logic [31:0] BASE = 32'h4000_0000;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [31:0]          addr = '0;
    logic                 wr_en = 1'b0;
    logic [31:0]          wdata = '0;
    logic                 rd_en = 1'b0;
    logic [31:0]          rd_data;
    logic [NREG-1:0][31:0] ctrl;

    int n_checks = 0;
    int n_errors = 0;
    logic [31:0] model [NREG];

    always #5 clk = ~clk;

    sca_reg_bank #(.NUM_REGS(NREG), .BASE_ADDR(BASE)) dut_i (
        .clk_i(clk), .rst_i(rst), .addr_i(addr), .wr_en_i(wr_en),
        .wdata_i(wdata), .rd_en_i(rd_en), .rd_data_o(rd_data), .ctrl_o(ctrl)
    );

    function automatic logic [31:0] a_of(int k, int kind);
        return BASE + 32'(16 * k) + 32'(4 * kind);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [31:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic check_all_ctrl(string req);
        for (int k = 0; k < NREG; k++) check(req, ctrl[k], model[k]);
    endtask

    task automatic t_reset();
        logic [31:0] r;
        for (int k = 0; k < NREG; k++) model[k] = '0;
        check_all_ctrl("R8 reset ctrl");
        check("R8 reset rd_data", rd_data, 32'h0);
        bus_read(a_of(2, 2), r);
        check("R8 reset status read", r, 32'h0);
    endtask

    task automatic t_set();
        logic [31:0] r;
        bus_write(a_of(1, 0), 32'h0000_00F0);
        model[1] = 32'h0000_00F0;
        check("R2 R11 set ctrl", ctrl[1], model[1]);
        check_all_ctrl("R4 other regs");
        bus_read(a_of(1, 2), r);
        check("R5 status read", r, model[1]);
        bus_write(a_of(1, 0), 32'h0F00_0001);
        model[1] = 32'h0F00_00F1;
        check("R4 set keeps zero-mask bits", ctrl[1], model[1]);
    endtask

    task automatic t_clear();
        logic [31:0] r;
        bus_write(a_of(1, 1), 32'h0000_0011);
        model[1] = 32'h0F00_00E0;
        check("R3 clear", ctrl[1], model[1]);
        bus_read(a_of(1, 2), r);
        check("R3 clear readback", r, model[1]);
        bus_write(a_of(1, 1), 32'h0);
        check("R4 zero clear mask", ctrl[1], model[1]);
    endtask

    task automatic t_alias_reads();
        logic [31:0] r;
        bus_read(a_of(1, 0), r);
        check("R6 set alias reads zero", r, 32'h0);
        bus_read(a_of(1, 1), r);
        check("R6 clear alias reads zero", r, 32'h0);
        @(negedge clk);
        check("R5 idle rd_data zero", rd_data, 32'h0);
    endtask

    task automatic t_status_write();
        bus_write(a_of(1, 2), 32'hFFFF_FFFF);
        check_all_ctrl("R7 status write ignored");
    endtask

    task automatic t_unmapped();
        logic [31:0] r;
        bus_write(a_of(0, 3), 32'hFFFF_FFFF);
        bus_write(a_of(NREG, 0), 32'hFFFF_FFFF);
        bus_write(BASE + 32'h0000_1000, 32'hFFFF_FFFF);
        check_all_ctrl("R10 unmapped writes ignored");
        bus_read(a_of(2, 3), r);
        check("R10 unmapped slot reads zero", r, 32'h0);
        bus_write(a_of(0, 0), 32'h0000_8000);
        model[0] = 32'h0000_8000;
        bus_read(BASE + 32'h0000_1008, r);
        check("R10 out-of-window read zero", r, 32'h0);
        bus_read(a_of(0, 2) | 32'h3, r);
        check("R1 low address bits ignored", r, model[0]);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        addr = a_of(NREG - 1, 0); wdata = 32'hA5A5_0000; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        model[NREG-1] = 32'hA5A5_0000;
        check("R11 ctrl after edge", ctrl[NREG-1], model[NREG-1]);
        addr = a_of(NREG - 1, 2); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check("R9 next-cycle read", rd_data, model[NREG-1]);
        check_all_ctrl("R1 R4 only last reg changed");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_set();
        t_clear();
        t_alias_reads();
        t_status_write();
        t_unmapped();
        t_back_to_back();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule